// File: doc/BRIEF.md
# Video Black-Level Clamp and Gain Control Loop

This block closes the digital half of the control loops around a two-channel video digitiser. One channel carries luma or composite video and the other carries chroma. Each clock the block accepts an 8-bit code per channel, together with an underflow flag and an overflow flag per channel. It also takes three control inputs: a sync-tip gate, a back-porch gate and an active-low peak-white limiter enable. From these it produces three signed charge-pump commands: luma gain, luma offset and chroma offset. Each command also feeds a saturating integrator, so the settled gain and offset levels can be observed directly.

The two clamps act only inside the back-porch gate. They push the luma code toward 64 and the chroma code toward 128. The gain loop has two parts. Inside the sync gate it trims the sync tip with a small step in either direction. When the limiter is enabled, a large one-sided step cuts the gain whenever luma overflows, with or without the sync gate. For start-up, a fast-precharge input multiplies every step by 8 for the first few lines after reset. A line ends on each falling edge of the synchronised back-porch gate.

The block also registers both codes in one of three output formats: offset binary, two's complement or disabled. Samples arrive with `in_valid` and there is no `ready`: the block accepts one sample per clock and never applies back-pressure. Formatted data leaves with `out_valid` one cycle later. The commands are plain control outputs.

Top module: `vid_loop_ctrl`

## Requirements
- R1: A sample presented with `in_valid` at clock edge k sets the three commands at edge k+3. The gate inputs go through a two-flop synchroniser, and the data is delayed by the same two stages, so a gate level is paired with the sample presented in the same cycle.
- R2: While the back-porch gate is high, the luma clamp command is +54 when the luma code is below 64 or underflows. It is -54 when the code is 64 or more, or when the code overflows.
- R3: While the back-porch gate is high, the chroma clamp command is +54 when the chroma code is below 128 or underflows. It is -54 when the code is above 128 or overflows, and 0 at exactly 128.
- R4: While the back-porch gate is low, both clamp commands are 0.
- R5: While the sync gate is high, the gain command is +8 for a luma underflow. For an in-range code it is -8. For an overflow it is also -8 when the limiter is disabled.
- R6: While `pw_en_n` is 0, a luma overflow gives a gain command of +540, whatever the sync gate. A positive gain command lowers the gain.
- R7: With the sync gate low, the gain command is 0 unless the limiter is enabled and luma overflows.
- R8: The per-channel format code is `2'd0` = two's complement (MSB of the binary code inverted), `2'd1` = output disabled (`*_oe` = 0, data 0), and `2'd2` or `2'd3` = offset binary. The format takes effect at the edge after the sample.
- R9: In both formats, underflow is output as binary code 0x00 (two's complement 0x80) and overflow as 0xFF (two's complement 0x7F).
- R10: Each integrator is 16 bits wide and resets to 0x8000. At every edge it adds the current command, and it saturates at 0x0000 and 0xFFFF.
- R11: While `fast_en` is 1 and fewer than PRE_LINES falling edges of the synchronised back-porch gate have been seen since reset, every command is multiplied by 8.
- R12: A sample with `in_valid` low yields all-zero commands at its R1 slot. `out_valid` equals `in_valid` delayed by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample valid |
| y_code | input | 8 | Luma ADC code |
| y_under | input | 1 | Luma underflow |
| y_over | input | 1 | Luma overflow |
| c_code | input | 8 | Chroma ADC code |
| c_under | input | 1 | Chroma underflow |
| c_over | input | 1 | Chroma overflow |
| gate_sync | input | 1 | Sync-tip gate |
| gate_bp | input | 1 | Back-porch gate |
| pw_en_n | input | 1 | Peak-white limiter enable, active low |
| fast_en | input | 1 | Fast precharge enable |
| y_fmt | input | 2 | Luma output format |
| c_fmt | input | 2 | Chroma output format |
| out_valid | output | 1 | Formatted data valid |
| y_out | output | 8 | Formatted luma code |
| y_oe | output | 1 | Luma output enable |
| c_out | output | 8 | Formatted chroma code |
| c_oe | output | 1 | Chroma output enable |
| agc_cmd | output | 14 | Signed gain pump command |
| yclp_cmd | output | 14 | Signed luma clamp command |
| cclp_cmd | output | 14 | Signed chroma clamp command |
| agc_lvl | output | 16 | Gain integrator |
| yclp_lvl | output | 16 | Luma clamp integrator |
| cclp_lvl | output | 16 | Chroma clamp integrator |

## Verification
The bench builds the block with 8-bit codes, 14-bit commands, 16-bit integrators and PRE_LINES = 2. With 8-bit codes, an open-loop sweep can present every luma code under every flag state and every gate and limiter combination, with the chroma code swept in reverse. With only two precharge lines, the end of the ×8 window is reached within a few short gate pulses. Closed-loop runs then feed a bench model of the converter whose codes follow the integrators. These runs check that the luma clamp settles at 64 ±1, that the chroma clamp settles at 128 ±1, and that the limiter holds luma at or below 255.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [1:0] {
    FMT_TWOS = 2'd0,
    FMT_OFF  = 2'd1,
    FMT_BIN  = 2'd2,
    FMT_BIN2 = 2'd3
  } fmt_e;
endpackage

// File: rtl/vlc_sync.sv
module vlc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/vlc_pump.sv
module vlc_pump #(
  parameter int CODE_W     = 8,
  parameter int CMD_W      = 14,
  parameter int Y_BLACK    = 64,
  parameter int C_BLACK    = 128,
  parameter int CLAMP_STEP = 54,
  parameter int SYNC_STEP  = 8,
  parameter int PEAK_STEP  = 540,
  parameter int PRE_LINES  = 4,
  parameter int PRE_SHIFT  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fast_en,
  input  logic                    s_valid,
  input  logic [CODE_W-1:0]       y_code,
  input  logic                    y_under,
  input  logic                    y_over,
  input  logic [CODE_W-1:0]       c_code,
  input  logic                    c_under,
  input  logic                    c_over,
  input  logic                    g_sync,
  input  logic                    g_bp,
  input  logic                    pw_en_n,
  output logic signed [CMD_W-1:0] agc_cmd,
  output logic signed [CMD_W-1:0] yclp_cmd,
  output logic signed [CMD_W-1:0] cclp_cmd
);
  localparam int CNT_W = $clog2(PRE_LINES + 1);
  localparam logic signed [CMD_W-1:0] P_CLAMP = CMD_W'(CLAMP_STEP);
  localparam logic signed [CMD_W-1:0] P_SYNC  = CMD_W'(SYNC_STEP);
  localparam logic signed [CMD_W-1:0] P_PEAK  = CMD_W'(PEAK_STEP);

  logic [CNT_W-1:0] line_cnt;
  logic             bp_prev;
  logic             pre_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      bp_prev  <= 1'b0;
    end else begin
      bp_prev <= g_bp;
      if (bp_prev && !g_bp && line_cnt != CNT_W'(PRE_LINES))
        line_cnt <= line_cnt + 1'b1;
    end
  end

  assign pre_on = fast_en && (line_cnt < CNT_W'(PRE_LINES));

  logic signed [CMD_W-1:0] agc_b, ycl_b, ccl_b;

  always_comb begin
    // gain loop: limiter first, then sync-tip regulation
    if (y_over && !pw_en_n)   agc_b = P_PEAK;
    else if (g_sync)          agc_b = y_under ? P_SYNC : -P_SYNC;
    else                      agc_b = '0;

    if (!g_bp)                                        ycl_b = '0;
    else if (y_under || (!y_over && y_code < CODE_W'(Y_BLACK)))
                                                      ycl_b = P_CLAMP;
    else                                              ycl_b = -P_CLAMP;

    if (!g_bp)                                        ccl_b = '0;
    else if (c_under || (!c_over && c_code < CODE_W'(C_BLACK)))
                                                      ccl_b = P_CLAMP;
    else if (c_over || c_code > CODE_W'(C_BLACK))     ccl_b = -P_CLAMP;
    else                                              ccl_b = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !s_valid) begin
      agc_cmd  <= '0;
      yclp_cmd <= '0;
      cclp_cmd <= '0;
    end else if (pre_on) begin
      agc_cmd  <= agc_b <<< PRE_SHIFT;
      yclp_cmd <= ycl_b <<< PRE_SHIFT;
      cclp_cmd <= ccl_b <<< PRE_SHIFT;
    end else begin
      agc_cmd  <= agc_b;
      yclp_cmd <= ycl_b;
      cclp_cmd <= ccl_b;
    end
  end
endmodule

// File: rtl/vlc_integ.sv
module vlc_integ #(
  parameter int CMD_W = 14,
  parameter int LVL_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [CMD_W-1:0] cmd,
  output logic [LVL_W-1:0]        lvl
);
  localparam int SUM_W = LVL_W + 2;
  localparam logic signed [SUM_W-1:0] TOP = $signed({2'b00, {LVL_W{1'b1}}});

  logic signed [SUM_W-1:0] sum;
  assign sum = $signed({2'b00, lvl}) + SUM_W'(cmd);

  always_ff @(posedge clk) begin
    if (!rst_n)            lvl <= {1'b1, {(LVL_W-1){1'b0}}};
    else if (sum < 0)      lvl <= '0;
    else if (sum > TOP)    lvl <= '1;
    else                   lvl <= sum[LVL_W-1:0];
  end
endmodule

// File: rtl/vlc_fmt.sv
module vlc_fmt #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              under,
  input  logic              over,
  input  logic [1:0]        fmt,
  output logic [CODE_W-1:0] dout,
  output logic              oe
);
  import vlc_pkg::*;
  logic [CODE_W-1:0] bin;
  fmt_e              sel;

  assign bin = under ? '0 : (over ? '1 : code);
  assign sel = fmt_e'(fmt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      unique case (sel)
        FMT_TWOS: begin dout <= {~bin[CODE_W-1], bin[CODE_W-2:0]}; oe <= 1'b1; end
        FMT_OFF:  begin dout <= '0;  oe <= 1'b0; end
        default:  begin dout <= bin; oe <= 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/vid_loop_ctrl.sv
module vid_loop_ctrl #(
  parameter int CODE_W     = 8,
  parameter int CMD_W      = 14,
  parameter int LVL_W      = 16,
  parameter int Y_BLACK    = 64,
  parameter int C_BLACK    = 128,
  parameter int CLAMP_STEP = 54,
  parameter int SYNC_STEP  = 8,
  parameter int PEAK_STEP  = 540,
  parameter int PRE_LINES  = 4,
  parameter int PRE_SHIFT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] y_code,
  input  logic              y_under,
  input  logic              y_over,
  input  logic [CODE_W-1:0] c_code,
  input  logic              c_under,
  input  logic              c_over,
  input  logic              gate_sync,
  input  logic              gate_bp,
  input  logic              pw_en_n,
  input  logic              fast_en,
  input  logic [1:0]        y_fmt,
  input  logic [1:0]        c_fmt,
  output logic              out_valid,
  output logic [CODE_W-1:0] y_out,
  output logic              y_oe,
  output logic [CODE_W-1:0] c_out,
  output logic              c_oe,
  output logic [CMD_W-1:0]  agc_cmd,
  output logic [CMD_W-1:0]  yclp_cmd,
  output logic [CMD_W-1:0]  cclp_cmd,
  output logic [LVL_W-1:0]  agc_lvl,
  output logic [LVL_W-1:0]  yclp_lvl,
  output logic [LVL_W-1:0]  cclp_lvl
);
  localparam int NLOOP = 3;
  localparam int NCH   = 2;

  // gate synchroniser, aligned with the two-stage data delay
  logic [2:0] g_s;
  logic       s2_sync, s2_bp, s2_pwn;
  vlc_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({gate_sync, gate_bp, pw_en_n}), .q(g_s)
  );
  assign s2_sync = g_s[2];
  assign s2_bp   = g_s[1];
  assign s2_pwn  = g_s[0];

  logic              s1_valid, s2_valid;
  logic [CODE_W-1:0] s1_y, s2_y, s1_c, s2_c;
  logic              s1_yu, s1_yo, s1_cu, s1_co;
  logic              s2_yu, s2_yo, s2_cu, s2_co;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s2_valid <= 1'b0;
      s1_y <= '0; s2_y <= '0; s1_c <= '0; s2_c <= '0;
      {s1_yu, s1_yo, s1_cu, s1_co} <= '0;
      {s2_yu, s2_yo, s2_cu, s2_co} <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_y <= y_code; s1_c <= c_code;
      {s1_yu, s1_yo, s1_cu, s1_co} <= {y_under, y_over, c_under, c_over};
      s2_valid <= s1_valid;
      s2_y <= s1_y; s2_c <= s1_c;
      {s2_yu, s2_yo, s2_cu, s2_co} <= {s1_yu, s1_yo, s1_cu, s1_co};
    end
  end

  logic signed [CMD_W-1:0] cmd_arr [NLOOP];
  logic [LVL_W-1:0]        lvl_arr [NLOOP];

  vlc_pump #(
    .CODE_W(CODE_W), .CMD_W(CMD_W), .Y_BLACK(Y_BLACK), .C_BLACK(C_BLACK),
    .CLAMP_STEP(CLAMP_STEP), .SYNC_STEP(SYNC_STEP), .PEAK_STEP(PEAK_STEP),
    .PRE_LINES(PRE_LINES), .PRE_SHIFT(PRE_SHIFT)
  ) u_pump (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .s_valid(s2_valid),
    .y_code(s2_y), .y_under(s2_yu), .y_over(s2_yo),
    .c_code(s2_c), .c_under(s2_cu), .c_over(s2_co),
    .g_sync(s2_sync), .g_bp(s2_bp), .pw_en_n(s2_pwn),
    .agc_cmd(cmd_arr[0]), .yclp_cmd(cmd_arr[1]), .cclp_cmd(cmd_arr[2])
  );

  for (genvar i = 0; i < NLOOP; i++) begin : g_int
    vlc_integ #(.CMD_W(CMD_W), .LVL_W(LVL_W)) u_int (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_arr[i]), .lvl(lvl_arr[i])
    );
  end

  assign agc_cmd  = cmd_arr[0];
  assign yclp_cmd = cmd_arr[1];
  assign cclp_cmd = cmd_arr[2];
  assign agc_lvl  = lvl_arr[0];
  assign yclp_lvl = lvl_arr[1];
  assign cclp_lvl = lvl_arr[2];

  // output formatting, one register stage
  logic [CODE_W-1:0] f_code [NCH];
  logic              f_un   [NCH];
  logic              f_ov   [NCH];
  logic [1:0]        f_sel  [NCH];
  logic [CODE_W-1:0] f_out  [NCH];
  logic              f_oe   [NCH];

  assign f_code[0] = y_code;  assign f_code[1] = c_code;
  assign f_un[0]   = y_under; assign f_un[1]   = c_under;
  assign f_ov[0]   = y_over;  assign f_ov[1]   = c_over;
  assign f_sel[0]  = y_fmt;   assign f_sel[1]  = c_fmt;

  for (genvar i = 0; i < NCH; i++) begin : g_fmt
    vlc_fmt #(.CODE_W(CODE_W)) u_fmt (
      .clk(clk), .rst_n(rst_n), .code(f_code[i]), .under(f_un[i]),
      .over(f_ov[i]), .fmt(f_sel[i]), .dout(f_out[i]), .oe(f_oe[i])
    );
  end

  assign y_out = f_out[0];
  assign y_oe  = f_oe[0];
  assign c_out = f_out[1];
  assign c_oe  = f_oe[1];

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end
endmodule

// File: rtl/vlc_checker.sv
module vlc_checker #(
  parameter int CODE_W  = 8,
  parameter int CMD_W   = 14,
  parameter int LVL_W   = 16,
  parameter int C_BLACK = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        y_fmt,
  input logic              y_oe,
  input logic              s2_valid,
  input logic              s2_bp,
  input logic [CODE_W-1:0] s2_c,
  input logic              s2_cu,
  input logic              s2_co,
  input logic [CMD_W-1:0]  agc_cmd,
  input logic [CMD_W-1:0]  yclp_cmd,
  input logic [CMD_W-1:0]  cclp_cmd,
  input logic [LVL_W-1:0]  agc_lvl
);
  assert_clamp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_bp) |=> (yclp_cmd == '0 && cclp_cmd == '0));

  assert_invalid_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> (agc_cmd == '0 && yclp_cmd == '0 && cclp_cmd == '0));

  assert_chroma_on_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_bp && !s2_cu && !s2_co && s2_c == CODE_W'(C_BLACK)) |=> cclp_cmd == '0);

  assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_cmd == '0) |=> $stable(agc_lvl));

  assert_disabled_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && y_fmt == 2'd1) |=> !y_oe);
endmodule

bind vid_loop_ctrl vlc_checker #(
  .CODE_W(CODE_W), .CMD_W(CMD_W), .LVL_W(LVL_W), .C_BLACK(C_BLACK)
) u_vlc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .y_fmt(y_fmt), .y_oe(y_oe),
  .s2_valid(s2_valid), .s2_bp(s2_bp), .s2_c(s2_c), .s2_cu(s2_cu), .s2_co(s2_co),
  .agc_cmd(agc_cmd), .yclp_cmd(yclp_cmd), .cclp_cmd(cclp_cmd), .agc_lvl(agc_lvl)
);

// File: tb/vid_loop_ctrl_bench.sv
module vid_loop_ctrl_bench;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst_n, in_valid, y_under, y_over, c_under, c_over;
  logic gate_sync, gate_bp, pw_en_n, fast_en;
  logic [7:0] y_code, c_code;
  logic [1:0] y_fmt, c_fmt;
  logic out_valid, y_oe, c_oe;
  logic [7:0] y_out, c_out;
  logic [13:0] agc_cmd, yclp_cmd, cclp_cmd;
  logic [15:0] agc_lvl, yclp_lvl, cclp_lvl;

  always #(CLK_NS/2) clk = ~clk;

  vid_loop_ctrl #(.PRE_LINES(2)) u_vid_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .y_code(y_code), .y_under(y_under), .y_over(y_over),
    .c_code(c_code), .c_under(c_under), .c_over(c_over),
    .gate_sync(gate_sync), .gate_bp(gate_bp), .pw_en_n(pw_en_n), .fast_en(fast_en),
    .y_fmt(y_fmt), .c_fmt(c_fmt), .out_valid(out_valid),
    .y_out(y_out), .y_oe(y_oe), .c_out(c_out), .c_oe(c_oe),
    .agc_cmd(agc_cmd), .yclp_cmd(yclp_cmd), .cclp_cmd(cclp_cmd),
    .agc_lvl(agc_lvl), .yclp_lvl(yclp_lvl), .cclp_lvl(cclp_lvl)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  function automatic int scmd(input logic [13:0] v);
    return int'($signed(v));
  endfunction

  // expected pipeline (3 deep for commands, 1 deep for formatting)
  int  e_agc [3], e_ycl [3], e_ccl [3];
  bit  e_v   [3];
  int  f_y, f_c;
  bit  f_yoe, f_coe, f_v, f_on;

  function automatic int fmt_exp(input int code, input bit un, input bit ov,
                                 input int sel, output bit oe);
    int b;
    b = un ? 0 : (ov ? 255 : code);
    oe = (sel != 1);
    if (sel == 0) return b ^ 128;
    if (sel == 1) return 0;
    return b;
  endfunction

  task automatic do_reset(input bit fe);
    @(negedge clk);
    rst_n = 0; in_valid = 0; y_code = 0; c_code = 0;
    y_under = 0; y_over = 0; c_under = 0; c_over = 0;
    gate_sync = 0; gate_bp = 0; pw_en_n = 1; fast_en = fe; y_fmt = 2; c_fmt = 2;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_sweep();
    for (int i = 0; i < 3; i++) e_v[i] = 0;
    f_on = 0;
    for (int code = 0; code < 256 + 3; code++) begin
      for (int f = 0; f < 3; f++) begin
        for (int g = 0; g < 8; g++) begin
          int ya, yl, cl;
          bit yu, yo, cu, co, sa, bp, pn, v, oe;
          @(negedge clk);
          // compare previous samples (R1 latency 3, R8 latency 1)
          if (e_v[2]) begin
            chk(scmd(agc_cmd) == e_agc[2], "R1/R5/R6/R7 agc", scmd(agc_cmd), e_agc[2]);
            chk(scmd(yclp_cmd) == e_ycl[2], "R1/R2/R4 yclamp", scmd(yclp_cmd), e_ycl[2]);
            chk(scmd(cclp_cmd) == e_ccl[2], "R1/R3/R4 cclamp", scmd(cclp_cmd), e_ccl[2]);
          end
          if (f_on) begin
            chk(out_valid == f_v, "R12 out_valid", out_valid, f_v);
            if (f_v) begin
              chk(y_oe == f_yoe && (int'(y_out) == f_y), "R8/R9 y_out", y_out, f_y);
              chk(c_oe == f_coe && (int'(c_out) == f_c), "R8/R9 c_out", c_out, f_c);
            end
          end
          for (int k = 2; k > 0; k--) begin
            e_agc[k] = e_agc[k-1]; e_ycl[k] = e_ycl[k-1];
            e_ccl[k] = e_ccl[k-1]; e_v[k] = e_v[k-1];
          end
          if (code >= 256) begin
            in_valid = 0; e_v[0] = 0; f_on = 0;
            continue;
          end
          yu = (f == 1); yo = (f == 2);
          cu = (((f + 1) % 3) == 1); co = (((f + 1) % 3) == 2);
          sa = g[0]; bp = g[1]; pn = g[2];
          v  = ((code + g) % 7) != 0;
          // expected commands (R12: invalid gives zero)
          if (yo && !pn) ya = 540;
          else if (sa) ya = yu ? 8 : -8;
          else ya = 0;
          if (!bp) yl = 0;
          else if (yu || (!yo && code < 64)) yl = 54;
          else yl = -54;
          if (!bp) cl = 0;
          else if (cu || (!co && (255 - code) < 128)) cl = 54;
          else if (co || (255 - code) > 128) cl = -54;
          else cl = 0;
          e_agc[0] = v ? ya : 0; e_ycl[0] = v ? yl : 0; e_ccl[0] = v ? cl : 0;
          e_v[0] = 1;
          f_v = v; f_on = 1;
          f_y = fmt_exp(code, yu, yo, (code + g) % 3, oe); f_yoe = oe;
          f_c = fmt_exp(255 - code, cu, co, (code + f) % 3, oe); f_coe = oe;
          in_valid = v; y_code = 8'(code); c_code = 8'(255 - code);
          y_under = yu; y_over = yo; c_under = cu; c_over = co;
          gate_sync = sa; gate_bp = bp; pw_en_n = pn;
          y_fmt = 2'((code + g) % 3); c_fmt = 2'((code + f) % 3);
        end
      end
    end
  endtask

  // bench converter model driven from the integrators
  task automatic drive_model(input int ybase, input int cbase, input int agc_div);
    int yv, cv;
    yv = ybase + (int'(yclp_lvl) - 32768) / 256;
    if (agc_div != 0) yv = ybase - (int'(agc_lvl) - 32768) / agc_div;
    cv = cbase + (int'(cclp_lvl) - 32768) / 256;
    y_under = (yv < 0); y_over = (yv > 255);
    c_under = (cv < 0); c_over = (cv > 255);
    y_code = 8'((yv < 0) ? 0 : (yv > 255 ? 255 : yv));
    c_code = 8'((cv < 0) ? 0 : (cv > 255 ? 255 : cv));
  endtask

  initial begin
    int worst_y, worst_c, over_seen;
    do_reset(0);
    @(negedge clk);
    chk(agc_lvl == 16'h8000 && yclp_lvl == 16'h8000 && cclp_lvl == 16'h8000,
        "R10 reset level", agc_lvl, 32768);
    chk(agc_cmd == 0 && yclp_cmd == 0 && cclp_cmd == 0, "R12 reset cmd", agc_cmd, 0);
    chk(out_valid == 0, "R12 reset out_valid", out_valid, 0);

    run_sweep();

    // R7: limiter off, no sync gate -> gain level untouched
    do_reset(0);
    in_valid = 1; y_code = 255; y_over = 1; pw_en_n = 1;
    repeat (50) @(negedge clk);
    chk(agc_lvl == 16'h8000, "R7 agc idle", agc_lvl, 32768);

    // R2/R3 closed-loop clamp settling
    do_reset(0);
    in_valid = 1; gate_bp = 1;
    worst_y = 0; worst_c = 0;
    for (int n = 0; n < 1800; n++) begin
      @(negedge clk);
      if (n >= 1600) begin
        int dy, dc;
        dy = int'(y_code) - 64; dc = int'(c_code) - 128;
        if (dy < 0) dy = -dy;
        if (dc < 0) dc = -dc;
        if (dy > worst_y) worst_y = dy;
        if (dc > worst_c) worst_c = dc;
      end
      drive_model(100, 90, 0);
    end
    chk(worst_y <= 1, "R2 luma settles at 64", worst_y, 1);
    chk(worst_c <= 1, "R3 chroma settles at 128", worst_c, 1);

    // R6 closed-loop peak-white limiting
    do_reset(0);
    in_valid = 1; pw_en_n = 0; over_seen = 0;
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      if (n >= 300 && y_over) over_seen++;
      drive_model(300, 128, 64);
    end
    chk(over_seen == 0, "R6 luma kept <= 255", over_seen, 0);
    chk(agc_lvl > 16'h8000, "R6 gain reduced", agc_lvl, 32769);

    // R11 fast precharge for two lines, then R10 saturation
    do_reset(1);
    in_valid = 1; y_code = 0; c_code = 200; gate_bp = 1;
    repeat (10) @(negedge clk);
    chk(scmd(yclp_cmd) == 432, "R11 line0 x8 luma", scmd(yclp_cmd), 432);
    chk(scmd(cclp_cmd) == -432, "R11 line0 x8 chroma", scmd(cclp_cmd), -432);
    gate_bp = 0; repeat (10) @(negedge clk);
    gate_bp = 1; repeat (10) @(negedge clk);
    chk(scmd(yclp_cmd) == 432, "R11 line1 x8", scmd(yclp_cmd), 432);
    gate_bp = 0; repeat (10) @(negedge clk);
    gate_bp = 1; repeat (10) @(negedge clk);
    chk(scmd(yclp_cmd) == 54, "R11 after window", scmd(yclp_cmd), 54);
    chk(scmd(cclp_cmd) == -54, "R11 after window chroma", scmd(cclp_cmd), -54);
    repeat (1000) @(negedge clk);
    chk(yclp_lvl == 16'hFFFF, "R10 saturate high", yclp_lvl, 65535);
    chk(cclp_lvl == 16'h0000, "R10 saturate low", cclp_lvl, 0);

    finish_run();
  end
endmodule